// File: doc/BRIEF.md
# System Bus Target with Posted Write Buffer

This block sits on the system side of a processor-style bus and answers the cycles the bus master starts. On the clock where the active-low address strobe is low, it latches the quadword address, the active-low byte enables and the write and memory/IO qualifiers. It then returns an active-low ready after a fixed wait count. Reads are served from a small internal quadword memory, with one even-parity bit per byte lane. A read that may be cached can be answered as a four-beat burst. Addresses alias onto the memory through word index bits [IDX_W+2:3].

Writes are posted. Address, byte enables and data go into a small FIFO and ready is returned at once. The FIFO is drained into memory in the background, one entry every DRAIN_GAP cycles. An active-low buffer-empty output stays negated while any posted write has not yet reached memory. For each read the block also answers the master's caching intent: a cache-enable and a write-back select, both taken from a configured address window.

Top module: `busTgt`

## Requirements
- R1: Counting the strobe cycle as cycle 0, ready is never asserted in cycle 1. When no buffer condition holds it back, the first ready comes in cycle WAIT_STATES+2.
- R2: During a read ready, dataOut carries the addressed memory word. Byte lane i is dataOut bits 8i+7:8i. parOut[i] is chosen so that lane i together with parOut[i] holds an even number of ones. Outside read ready cycles, dataOut is zero.
- R3: A write that finds space in the buffer gets ready at the R1 latency, and dataIn is taken in that ready cycle. bufEmptyN is high in the cycle after the write's ready.
- R4: Only lanes whose beN bit is 0 are updated in memory, with beN[i] controlling byte lane i. All other lanes keep their old value.
- R5: The buffer holds BUF_DEPTH entries. A write that finds it full gets no ready until an entry has drained, so its latency exceeds the R1 latency.
- R6: One entry drains every DRAIN_GAP cycles while the buffer is not empty. bufEmptyN goes low once every entry has drained.
- R7: A read waits until the buffer is empty, so it returns the newest written bytes. A read that starts while writes are pending therefore has a latency above the R1 latency.
- R8: cacheEnN is low and wbSel is high only in read ready cycles of memory cycles (memIo=1) whose byte address lies in [CACHE_BASE, CACHE_LIMIT). On writes, IO cycles and out-of-window reads, cacheEnN is high and wbSel is low.
- R9: A memory read inside the window with cacheN low returns four back-to-back ready beats. Beat k returns the word whose index bits [4:3] equal the start bits plus k modulo 4, with the upper index bits fixed. Every other read gets a single beat.
- R10: rdyN is high after reset and in the cycle after the last beat of any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| adsN | input | 1 | Active-low address strobe |
| addrHi | input | 29 | Quadword address, bits 31:3 |
| beN | input | 8 | Active-low byte enables, bit i for lane i |
| wrRd | input | 1 | 1 = write, 0 = read |
| memIo | input | 1 | 1 = memory cycle, 0 = IO cycle |
| cacheN | input | 1 | Active-low master intent to cache (burst request) |
| dataIn | input | 64 | Write data from the master |
| rdyN | output | 1 | Active-low ready |
| dataOut | output | 64 | Read data |
| parOut | output | 8 | Even parity per byte lane |
| cacheEnN | output | 1 | Active-low cache enable response |
| wbSel | output | 1 | 1 = write-back, 0 = write-through |
| bufEmptyN | output | 1 | Active-low write buffer empty |

## Verification
A wrong buffer count or pointer shows up first as a wrong bufEmptyN level, in the cycle after a write's ready or after the last drain. It also shows up as a changed ready latency for the next write or read, and as stale or misplaced bytes at the next read of that word. A wrong wait counter or state moves the first ready away from cycle WAIT_STATES+2 of the very next cycle. A wrong beat counter breaks burst word order within four cycles. Wrong window decoding shows at once on cacheEnN and wbSel in the same ready cycle.

// File: rtl/busTgtPkg.sv
package busTgtPkg;
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READY
  } tgtState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       capture;
    logic       push;
    logic       readBeat;
    logic [1:0] beat;
  } tgtStrobe_t;
endpackage

// File: rtl/busTgtCtrl.sv
module busTgtCtrl
  import busTgtPkg::*;
#(
  parameter int WAIT_STATES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       adsN,
  input  logic       curWrite,
  input  logic       burstOk,
  input  logic       bufEmpty,
  input  logic       bufFull,
  output tgtStrobe_t strobe,
  output logic       rdyN
);
  localparam int CW = 2;
  localparam logic [CW-1:0] WAIT_LIM = CW'(WAIT_STATES);

  tgtState_e      state;
  logic [CW-1:0]  waitCnt;
  logic [1:0]     beat;
  logic           canGo;

  always_comb begin
    canGo           = curWrite ? !bufFull : bufEmpty;
    strobe.capture  = (state == ST_IDLE) && !adsN;
    strobe.push     = (state == ST_READY) && curWrite;
    strobe.readBeat = (state == ST_READY) && !curWrite;
    strobe.beat     = beat;
    rdyN            = (state != ST_READY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      beat    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!adsN) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
            beat    <= '0;
          end
        end
        ST_WAIT: begin
          if (waitCnt == WAIT_LIM) begin
            if (canGo) state <= ST_READY;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_READY: begin
          if (!curWrite && burstOk && beat != 2'd3) beat <= beat + 2'd1;
          else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/busTgtData.sv
module busTgtData
  import busTgtPkg::*;
#(
  parameter int          MEM_WORDS   = 16,
  parameter int          BUF_DEPTH   = 4,
  parameter int          DRAIN_GAP   = 16,
  parameter logic [31:0] CACHE_BASE  = 32'h0000_0000,
  parameter logic [31:0] CACHE_LIMIT = 32'h0000_0080
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtStrobe_t        strobe,
  input  logic [31:3]       addrHi,
  input  logic [LANES-1:0]  beN,
  input  logic              wrRd,
  input  logic              memIo,
  input  logic              cacheN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              curWrite,
  output logic              burstOk,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic [DATA_W-1:0] dataOut,
  output logic [LANES-1:0]  parOut,
  output logic              cacheEnN,
  output logic              wbSel
);
  // MEM_WORDS >= 8 and BUF_DEPTH a power of two (pointers wrap naturally)
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int GAP_W = $clog2(DRAIN_GAP + 1);

  logic [31:3]       capAddr;
  logic [LANES-1:0]  capBe;
  logic              capWr, capMio, capCacheN;
  logic              inWindow;
  logic [IDX_W-1:0]  writeIdx, readIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr   <= '0;
      capBe     <= '1;
      capWr     <= 1'b0;
      capMio    <= 1'b0;
      capCacheN <= 1'b1;
    end else if (strobe.capture) begin
      capAddr   <= addrHi;
      capBe     <= beN;
      capWr     <= wrRd;
      capMio    <= memIo;
      capCacheN <= cacheN;
    end
  end

  always_comb begin
    inWindow = ({capAddr, 3'b000} >= CACHE_BASE) && ({capAddr, 3'b000} < CACHE_LIMIT);
    curWrite = capWr;
    burstOk  = !capWr && capMio && inWindow && !capCacheN;
    writeIdx = capAddr[IDX_W+2:3];
    readIdx  = {capAddr[IDX_W+2:5], capAddr[4:3] + strobe.beat};
  end

  // posted write FIFO
  logic [IDX_W-1:0]  qIdx  [BUF_DEPTH];
  logic [LANES-1:0]  qBe   [BUF_DEPTH];
  logic [DATA_W-1:0] qData [BUF_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic [GAP_W-1:0]  gapCnt;
  logic              pop;

  assign pop      = (fill != '0) && (gapCnt == GAP_W'(DRAIN_GAP - 1));
  assign bufEmpty = (fill == '0);
  assign bufFull  = (fill == CNT_W'(BUF_DEPTH));

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      qIdx[wrPtr]  <= writeIdx;
      qBe[wrPtr]   <= capBe;
      qData[wrPtr] <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      fill   <= '0;
      gapCnt <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (pop) rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (fill == '0 || pop) gapCnt <= '0;
      else gapCnt <= gapCnt + 1'b1;
    end
  end

  // backing memory, lane-merged on drain
  logic [DATA_W-1:0] mem [MEM_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
    end else if (pop) begin
      for (int l = 0; l < LANES; l++) begin
        if (!qBe[rdPtr][l]) mem[qIdx[rdPtr]][8*l +: 8] <= qData[rdPtr][8*l +: 8];
      end
    end
  end

  assign dataOut  = strobe.readBeat ? mem[readIdx] : '0;
  assign cacheEnN = !(strobe.readBeat && capMio && inWindow);
  assign wbSel    = strobe.readBeat && capMio && inWindow;

  for (genvar l = 0; l < LANES; l++) begin : g_par
    assign parOut[l] = ^dataOut[8*l +: 8];
  end
endmodule

// File: rtl/busTgt.sv
module busTgt
  import busTgtPkg::*;
#(
  parameter int          WAIT_STATES = 1,
  parameter int          MEM_WORDS   = 16,
  parameter int          BUF_DEPTH   = 4,
  parameter int          DRAIN_GAP   = 16,
  parameter logic [31:0] CACHE_BASE  = 32'h0000_0000,
  parameter logic [31:0] CACHE_LIMIT = 32'h0000_0080
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        adsN,
  input  logic [31:3] addrHi,
  input  logic [7:0]  beN,
  input  logic        wrRd,
  input  logic        memIo,
  input  logic        cacheN,
  input  logic [63:0] dataIn,
  output logic        rdyN,
  output logic [63:0] dataOut,
  output logic [7:0]  parOut,
  output logic        cacheEnN,
  output logic        wbSel,
  output logic        bufEmptyN
);
  tgtStrobe_t strobe;
  logic curWrite, burstOk, bufEmpty, bufFull;

  busTgtCtrl #(.WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .adsN(adsN), .curWrite(curWrite), .burstOk(burstOk),
    .bufEmpty(bufEmpty), .bufFull(bufFull), .strobe(strobe), .rdyN(rdyN)
  );

  busTgtData #(
    .MEM_WORDS(MEM_WORDS), .BUF_DEPTH(BUF_DEPTH), .DRAIN_GAP(DRAIN_GAP),
    .CACHE_BASE(CACHE_BASE), .CACHE_LIMIT(CACHE_LIMIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrHi(addrHi), .beN(beN),
    .wrRd(wrRd), .memIo(memIo), .cacheN(cacheN), .dataIn(dataIn),
    .curWrite(curWrite), .burstOk(burstOk), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .dataOut(dataOut), .parOut(parOut), .cacheEnN(cacheEnN), .wbSel(wbSel)
  );

  assign bufEmptyN = !bufEmpty;
endmodule

// File: rtl/busTgtChecker.sv
module busTgtChecker (
  input logic        clk,
  input logic        rstN,
  input logic        adsN,
  input logic        wrRd,
  input logic        rdyN,
  input logic [63:0] dataOut,
  input logic [7:0]  parOut,
  input logic        cacheEnN,
  input logic        wbSel,
  input logic        bufEmptyN
);
  logic lastWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastWr <= 1'b0;
    else if (!adsN && rdyN) lastWr <= wrRd;
  end

  // R1: no ready in the clock right after the strobe
  p_no_early_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!adsN && rdyN) |=> rdyN);

  // R2: read data plus parity hold an even number of ones
  p_even_parity_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyN && !lastWr) |-> ($countones({dataOut, parOut}) % 2 == 0));

  // R3: a posted write leaves the buffer non-empty next cycle
  p_posted_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyN && lastWr) |=> bufEmptyN);

  // R7: reads only complete with an empty buffer
  p_read_drained_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyN && !lastWr) |-> !bufEmptyN);

  // R8: writes never get a cache response
  p_write_uncached_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdyN && lastWr) |-> (cacheEnN && !wbSel));

  // R8: cache enable only in read ready cycles, paired with write-back
  p_ken_read_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cacheEnN |-> (wbSel && !rdyN && !lastWr));
endmodule

bind busTgt busTgtChecker u_chk (
  .clk(clk), .rstN(rstN), .adsN(adsN), .wrRd(wrRd), .rdyN(rdyN),
  .dataOut(dataOut), .parOut(parOut), .cacheEnN(cacheEnN), .wbSel(wbSel),
  .bufEmptyN(bufEmptyN)
);

// File: tb/busTgt_test.sv
module busTgt_test;
  localparam int WAIT_ST = 1;
  localparam int MIN_LAT = WAIT_ST + 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adsN = 1'b1;
  logic [31:3] addrHi = '0;
  logic [7:0]  beN = '1;
  logic        wrRd = 1'b0;
  logic        memIo = 1'b1;
  logic        cacheN = 1'b1;
  logic [63:0] dataIn = '0;
  logic        rdyN;
  logic [63:0] dataOut;
  logic [7:0]  parOut;
  logic        cacheEnN, wbSel, bufEmptyN;

  int tests = 0;
  int fails = 0;
  logic [63:0] model [16];

  always #5 clk = ~clk;

  busTgt #(.WAIT_STATES(WAIT_ST), .MEM_WORDS(16), .BUF_DEPTH(4), .DRAIN_GAP(16),
           .CACHE_BASE(32'h0), .CACHE_LIMIT(32'h80)) uut (
    .clk(clk), .rstN(rstN), .adsN(adsN), .addrHi(addrHi), .beN(beN), .wrRd(wrRd),
    .memIo(memIo), .cacheN(cacheN), .dataIn(dataIn), .rdyN(rdyN), .dataOut(dataOut),
    .parOut(parOut), .cacheEnN(cacheEnN), .wbSel(wbSel), .bufEmptyN(bufEmptyN)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] evenPar(input logic [63:0] d);
    logic [7:0] p;
    for (int l = 0; l < 8; l++) p[l] = ^d[8*l +: 8];
    return p;
  endfunction

  function automatic logic [63:0] pattern(input int w);
    return 64'hA5C3_0F1E_7B2D_9684 ^ ({32'(w) * 32'h0101_0101, 32'(w) * 32'h0011_2233});
  endfunction

  task automatic issue(input logic [31:0] a, input logic [7:0] be, input logic wr,
                       input logic mio, input logic cn, input logic [63:0] d,
                       output int lat);
    @(negedge clk);
    adsN = 1'b0; addrHi = a[31:3]; beN = be; wrRd = wr; memIo = mio; cacheN = cn;
    dataIn = d;
    @(negedge clk);
    adsN = 1'b1;
    lat = 1;
    while (rdyN && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    if (rdyN) check(1'b0, "R1 ready timeout", 64'(lat), 64'(MIN_LAT));
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [7:0] be,
                         input logic [63:0] d, output int lat);
    issue(a, be, 1'b1, 1'b1, 1'b1, d, lat);
    check(cacheEnN == 1'b1 && wbSel == 1'b0, "R8 write uncached",
          {62'b0, cacheEnN, wbSel}, 64'h2);
    for (int l = 0; l < 8; l++)
      if (!be[l]) model[a[6:3]][8*l +: 8] = d[8*l +: 8];
  endtask

  task automatic doRead(input logic [31:0] a, input logic mio, input logic cn,
                        input bit burstExp, input bit cacheExp, output int lat);
    issue(a, 8'h00, 1'b0, mio, cn, 64'h0, lat);
    for (int k = 0; k < (burstExp ? 4 : 1); k++) begin
      logic [3:0] idx;
      idx = {a[6:5], 2'(a[4:3] + 2'(k))};
      if (k > 0) begin
        @(negedge clk);
        check(rdyN == 1'b0, "R9 burst beat ready", 64'(rdyN), 64'h0);
      end
      check(dataOut == model[idx], "R2/R9 read data", dataOut, model[idx]);
      check(parOut == evenPar(model[idx]), "R2 parity", 64'(parOut),
            64'(evenPar(model[idx])));
      check(cacheEnN == !cacheExp && wbSel == cacheExp, "R8 cache response",
            {62'b0, cacheEnN, wbSel}, {62'b0, !cacheExp, cacheExp});
    end
    @(negedge clk);
    check(rdyN == 1'b1, "R10 ready released", 64'(rdyN), 64'h1);
    check(dataOut == '0, "R2 data idle zero", dataOut, 64'h0);
  endtask

  task automatic waitEmpty();
    int n = 0;
    while (!bufEmptyN == 1'b0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(bufEmptyN == 1'b0, "R6 buffer drains", 64'(bufEmptyN), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    for (int w = 0; w < 16; w++) model[w] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rdyN == 1'b1, "R10 reset ready", 64'(rdyN), 64'h1);
    check(bufEmptyN == 1'b0, "R6 reset empty", 64'(bufEmptyN), 64'h0);
    check(cacheEnN == 1'b1, "R8 reset cache", 64'(cacheEnN), 64'h1);

    // R1 R3: first writes from empty buffer
    doWrite(32'h00, 8'h00, pattern(0), lat);
    check(lat == MIN_LAT, "R3 write latency", 64'(lat), 64'(MIN_LAT));
    @(negedge clk);
    check(bufEmptyN == 1'b1, "R3 pending after write", 64'(bufEmptyN), 64'h1);
    for (int w = 1; w < 4; w++) begin
      doWrite(32'(w * 8), 8'h00, pattern(w), lat);
      check(lat == MIN_LAT, "R3 write latency", 64'(lat), 64'(MIN_LAT));
    end
    // R5: fifth write finds the buffer full
    doWrite(32'h20, 8'h00, pattern(4), lat);
    check(lat > MIN_LAT, "R5 full buffer stalls", 64'(lat), 64'(MIN_LAT + 1));
    for (int w = 5; w < 16; w++) doWrite(32'(w * 8), 8'h00, pattern(w), lat);
    waitEmpty();

    // R1 R2 R8: sweep single reads across window boundary and aliases
    for (int a = 0; a < 32; a++) begin
      doRead(32'(a * 8), 1'b1, 1'b1, 1'b0, (a < 16), lat);
      check(lat == MIN_LAT, "R1 read latency", 64'(lat), 64'(MIN_LAT));
    end

    // R4 R7: single-lane writes then a read that must wait
    for (int l = 0; l < 8; l++)
      doWrite(32'h28, ~(8'h01 << l), {8{8'(8'hC0 + l)}} ^ 64'hFFFF_0000_FFFF_0000, lat);
    doRead(32'h28, 1'b1, 1'b1, 1'b0, 1'b1, lat);
    check(lat > MIN_LAT, "R7 read waits for drain", 64'(lat), 64'(MIN_LAT + 1));
    doWrite(32'h30, 8'b1010_0101, 64'h1122_3344_5566_7788, lat);
    doRead(32'h30, 1'b1, 1'b1, 1'b0, 1'b1, lat);
    check(model[6] != pattern(6), "R4 partial lanes merged", model[6], pattern(6));

    // R9: bursts with wrap order, and burst requests that are refused
    waitEmpty();
    doRead(32'h58, 1'b1, 1'b0, 1'b1, 1'b1, lat);
    check(lat == MIN_LAT, "R9 burst first beat latency", 64'(lat), 64'(MIN_LAT));
    doRead(32'h40, 1'b1, 1'b0, 1'b1, 1'b1, lat);
    doRead(32'h98, 1'b1, 1'b0, 1'b0, 1'b0, lat);
    doRead(32'h10, 1'b0, 1'b0, 1'b0, 1'b0, lat);
    doRead(32'h78, 1'b1, 1'b0, 1'b1, 1'b1, lat);
    doRead(32'h80, 1'b1, 1'b0, 1'b0, 1'b0, lat);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule